// File: doc/BRIEF.md
# Timer Capture/Compare Status Register

This block is the status and control byte of a free-running timer. It also holds the timer's up-counter and its four capture registers. Seven event flags sit in the byte: four for input capture, two for compare match and one for counter overflow. A single control bit chooses whether compare match A resets the counter. Hardware events set the flags. Software reads the byte and clears chosen flags over a one-register bus of read and write strobes.

A flag can only be cleared on purpose. Software must first read the byte while the flag shows 1, and then write 0 to that bit. Capture channels A and B can each be buffered. When buffering is on, a new capture on the primary channel first pushes the old primary value into the partner register (C for A, D for B), and then loads the counter. Entering a low-power mode wipes the byte and all pending read history.

Top module: `tmr_status_top`

## Requirements
- R1: After reset, `rdData` reads 0x00, `count` is 0 and `irq` is 0.
- R2: Status bit layout is 7=capture A, 6=capture B, 5=capture C, 4=capture D, 3=compare A, 2=compare B, 1=overflow, 0=counter-clear select. `capEdge[3]`, `capEdge[2]`, `capEdge[1]` and `capEdge[0]` strobe channels A, B, C and D. On a strobe the channel latches `count` and sets its flag on the next clock.
- R3: Writing 1 to bits 7..1 never sets a flag. Bit 0 takes the written value on every write.
- R4: A flag clears only when 0 is written to it, and only if an earlier read returned that bit as 1. Any write consumes all read history, so a second 0-write without a new read leaves the flags unchanged.
- R5: When a flag's set event and its clearing write fall in the same cycle, the flag stays 1.
- R6: While `bufEnA` is 1, a channel A strobe copies the old `capA` into `capC` before `capA` takes `count`. A channel C strobe is then ignored: it does not load `capC` and does not set the flag. Channel B and `capD` behave the same way under `bufEnB`.
- R7: With `tickEn` high, the counter advances by one per clock. A compare match (`count` equal to the compare value on a tick) sets that compare flag. When bit 0 is 1, a match on A loads 0 into the counter instead of incrementing it.
- R8: A tick at `count` = 0xFFFF that is not a clearing match wraps the counter to 0 and sets the overflow flag.
- R9: While `lowPower` is high, the status byte clears to 0x00 on each clock and all read history is dropped.
- R10: `irq[6:0]` equals status bits 7..1 ANDed bit by bit with `irqEn[6:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowPower | input | 1 | High while a low-power mode is active; wipes the status byte |
| tickEn | input | 1 | Counter increment enable from the prescaler |
| capEdge | input | 4 | Capture strobes for channels A, B, C, D (bit 3 down to 0) |
| bufEnA | input | 1 | Buffered capture for channel A into C |
| bufEnB | input | 1 | Buffered capture for channel B into D |
| cmpValA | input | 16 | Compare value A |
| cmpValB | input | 16 | Compare value B |
| irqEn | input | 7 | Per-flag interrupt enables, aligned with status bits 7..1 |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Current status byte |
| count | output | 16 | Counter value |
| capA | output | 16 | Capture register A |
| capB | output | 16 | Capture register B |
| capC | output | 16 | Capture register C / buffer for A |
| capD | output | 16 | Capture register D / buffer for B |
| irq | output | 7 | Interrupt requests |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `lowPower` is low whenever a clearing write is being judged. They treat a flag's fall as legal only after a read armed it, or after a low-power cycle. The stimulus never raises read and write in the same cycle, and it keeps `tickEn` low during bus sequences so that captured values are known exactly. It changes `bufEnA`/`bufEnB` only between strobes. It re-applies reset before each counter test so that counts start from 0.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int FLAG_W = 7;

  typedef struct packed {
    logic [FLAG_W-1:0] clrFlag;
    logic              selWr;
    logic              selVal;
    logic              wipe;
  } ctlStrb_t;
endpackage

// File: rtl/tcsr_ctrl.sv
`timescale 1ns/1ps
module tcsr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowPower,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [7:0]        wrData,
  input  logic [FLAG_W-1:0] flagsIn,
  output ctlStrb_t          strb
);
  logic [FLAG_W-1:0] armed;

  // read-while-one tracker: armed by reads, consumed by any write
  always_ff @(posedge clk) begin
    if (!rstN) armed <= '0;
    else if (lowPower) armed <= '0;
    else armed <= (regWr ? '0 : armed) | (regRd ? flagsIn : '0);
  end

  always_comb begin
    strb.clrFlag = regWr ? (armed & ~wrData[7:1]) : '0;
    strb.selWr   = regWr;
    strb.selVal  = wrData[0];
    strb.wipe    = lowPower;
  end

  // R4: a flag falls only if it was armed, or a low-power cycle wiped it
  a_r4_clear_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    !lowPower |=> ($past(lowPower) ||
                   (($past(flagsIn) & ~flagsIn & ~$past(armed)) == '0)));
endmodule

// File: rtl/tcsr_dp.sv
`timescale 1ns/1ps
module tcsr_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [3:0]        capEdge,
  input  logic              bufEnA,
  input  logic              bufEnB,
  input  logic [CNT_W-1:0]  cmpValA,
  input  logic [CNT_W-1:0]  cmpValB,
  input  logic [FLAG_W-1:0] irqEn,
  input  ctlStrb_t          strb,
  output logic [FLAG_W-1:0] flags,
  output logic              clrSel,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capA,
  output logic [CNT_W-1:0]  capB,
  output logic [CNT_W-1:0]  capC,
  output logic [CNT_W-1:0]  capD,
  output logic [FLAG_W-1:0] irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]        bufEn;
  logic [3:0]        capSet;
  logic [CNT_W-1:0]  priVal [2];
  logic [CNT_W-1:0]  secVal [2];
  logic              matchA, matchB, wrapHit;
  logic [FLAG_W-1:0] setVec;

  assign bufEn = {bufEnB, bufEnA};

  // channel pair g: primary A/B, partner C/D
  for (genvar g = 0; g < 2; g++) begin : gPair
    logic [CNT_W-1:0] priReg, secReg;
    logic priHit, secHit;
    assign priHit = capEdge[3-g];
    assign secHit = capEdge[1-g] && !bufEn[g];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        priReg <= '0;
        secReg <= '0;
      end else begin
        if (priHit) begin
          priReg <= count;
          if (bufEn[g]) secReg <= priReg;
        end
        if (secHit) secReg <= count;
      end
    end
    assign priVal[g]   = priReg;
    assign secVal[g]   = secReg;
    assign capSet[3-g] = priHit;
    assign capSet[1-g] = secHit;
  end

  assign capA = priVal[0];
  assign capB = priVal[1];
  assign capC = secVal[0];
  assign capD = secVal[1];

  assign matchA  = tickEn && (count == cmpValA);
  assign matchB  = tickEn && (count == cmpValB);
  assign wrapHit = tickEn && (count == CNT_MAX) && !(clrSel && matchA);
  assign setVec  = {capSet, matchA, matchB, wrapHit};

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (tickEn) count <= (clrSel && matchA) ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.wipe) begin
      flags  <= '0;
      clrSel <= 1'b0;
    end else begin
      flags <= (flags & ~strb.clrFlag) | setVec;
      if (strb.selWr) clrSel <= strb.selVal;
    end
  end

  assign irq = flags & irqEn;

  // R3: a flag never rises without a hardware event
  a_r3_no_sw_set: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(setVec)) == '0));
  // R5: every event lands, even against a clearing write
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wipe |=> (($past(setVec) & ~flags) == '0));
  // R9: low power empties the byte
  a_r9_wipe: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> (flags == '0 && !clrSel));
  // R6: buffered capture shifts the old value into the partner
  a_r6_buffer_shift: assert property (@(posedge clk) disable iff (!rstN)
    (capEdge[3] && bufEnA) |=> (capC == $past(capA)));
  // R7: clearing match returns the counter to zero
  a_r7_clear_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && clrSel && count == cmpValA) |=> (count == '0));
  // R8: wrap gives zero and the overflow flag
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && count == CNT_MAX && !(clrSel && count == cmpValA) && !strb.wipe)
      |=> (count == '0 && flags[0]));
endmodule

// File: rtl/tmr_status_top.sv
`timescale 1ns/1ps
module tmr_status_top
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowPower,
  input  logic              tickEn,
  input  logic [3:0]        capEdge,
  input  logic              bufEnA,
  input  logic              bufEnB,
  input  logic [CNT_W-1:0]  cmpValA,
  input  logic [CNT_W-1:0]  cmpValB,
  input  logic [FLAG_W-1:0] irqEn,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capA,
  output logic [CNT_W-1:0]  capB,
  output logic [CNT_W-1:0]  capC,
  output logic [CNT_W-1:0]  capD,
  output logic [FLAG_W-1:0] irq
);
  ctlStrb_t          strb;
  logic [FLAG_W-1:0] flags;
  logic              clrSel;

  tcsr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .regRd(regRd),
    .regWr(regWr), .wrData(wrData), .flagsIn(flags), .strb(strb)
  );

  tcsr_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capEdge(capEdge),
    .bufEnA(bufEnA), .bufEnB(bufEnB), .cmpValA(cmpValA), .cmpValB(cmpValB),
    .irqEn(irqEn), .strb(strb), .flags(flags), .clrSel(clrSel),
    .count(count), .capA(capA), .capB(capB), .capC(capC), .capD(capD),
    .irq(irq)
  );

  assign rdData = {flags, clrSel};
endmodule

// File: tb/tb_tmr_status_top.sv
`timescale 1ns/1ps
module tb_tmr_status_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lowPower = 1'b0;
  logic        tickEn = 1'b0;
  logic [3:0]  capEdge = '0;
  logic        bufEnA = 1'b0, bufEnB = 1'b0;
  logic [15:0] cmpValA = 16'h1234, cmpValB = 16'h1234;
  logic [6:0]  irqEn = '0;
  logic        regRd = 1'b0, regWr = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [15:0] count, capA, capB, capC, capD;
  logic [6:0]  irq;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_status_top dut (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .tickEn(tickEn),
    .capEdge(capEdge), .bufEnA(bufEnA), .bufEnB(bufEnB),
    .cmpValA(cmpValA), .cmpValB(cmpValB), .irqEn(irqEn),
    .regRd(regRd), .regWr(regWr), .wrData(wrData), .rdData(rdData),
    .count(count), .capA(capA), .capB(capB), .capC(capC), .capD(capD),
    .irq(irq)
  );

  // {cap[3:0], rd, wr, wd[7:0], expected status[7:0]}
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    {4'h8, 1'b0, 1'b0, 8'h00, 8'h80},  // R2 capture A
    {4'h0, 1'b0, 1'b1, 8'h00, 8'h80},  // R4 no read yet
    {4'h0, 1'b1, 1'b0, 8'h00, 8'h80},
    {4'h0, 1'b0, 1'b1, 8'h01, 8'h01},  // R4 clear A, R3 bit0 set
    {4'h7, 1'b0, 1'b0, 8'h00, 8'h71},  // R2 B, C, D
    {4'h0, 1'b0, 1'b1, 8'hFF, 8'h71},  // R3 ones set nothing
    {4'h0, 1'b1, 1'b0, 8'h00, 8'h71},
    {4'h0, 1'b0, 1'b1, 8'hDF, 8'h51},  // R4 clear C only
    {4'h0, 1'b0, 1'b1, 8'h00, 8'h50},  // R4 history consumed
    {4'h0, 1'b1, 1'b0, 8'h00, 8'h50},
    {4'h4, 1'b0, 1'b1, 8'h00, 8'h40}   // R5 B set wins, D cleared
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busOp(logic [3:0] cap, logic rd, logic wr, logic [7:0] wd);
    capEdge = cap; regRd = rd; regWr = wr; wrData = wd;
    @(negedge clk);
    capEdge = '0; regRd = 1'b0; regWr = 1'b0; wrData = '0;
  endtask

  task automatic runTicks(int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    chk("R1 reset status", {8'h0, rdData}, 16'h0000);
    chk("R1 reset count", count, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      busOp(VEC[i][21:18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
      chk($sformatf("R2-R5 vector %0d", i), {8'h0, rdData}, {8'h0, VEC[i][7:0]});
    end

    doReset();
    chk("R1 reset after vectors", {8'h0, rdData}, 16'h0000);
    chk("R1 irq idle", {9'h0, irq}, 16'h0000);

    // R7 compare match with counter clear
    cmpValA = 16'd5; cmpValB = 16'd3; irqEn = 7'h7F;
    busOp(4'h0, 1'b0, 1'b1, 8'h01);
    runTicks(6);
    chk("R7 counter cleared on match A", count, 16'h0000);
    chk("R7 compare flags", {8'h0, rdData}, 16'h000D);
    chk("R10 irq all enabled", {9'h0, irq}, 16'h0006);
    irqEn = 7'h04;
    #1;
    chk("R10 irq masked", {9'h0, irq}, 16'h0004);

    // R8 overflow wrap
    doReset();
    cmpValA = 16'h8000; cmpValB = 16'h8000;
    runTicks(65536);
    chk("R8 wrap count", count, 16'h0000);
    chk("R8 overflow flag", {8'h0, rdData}, 16'h000E);

    // R6 buffered capture
    doReset();
    bufEnA = 1'b1;
    runTicks(7);
    chk("R7 count advance", count, 16'd7);
    busOp(4'h8, 1'b0, 1'b0, 8'h00);
    chk("R6 first capture A", capA, 16'd7);
    chk("R6 first buffer C", capC, 16'd0);
    runTicks(3);
    busOp(4'h8, 1'b0, 1'b0, 8'h00);
    chk("R6 second capture A", capA, 16'd10);
    chk("R6 shifted into C", capC, 16'd7);
    busOp(4'h2, 1'b0, 1'b0, 8'h00);
    chk("R6 C strobe ignored value", capC, 16'd7);
    chk("R6 C strobe ignored flag", {8'h0, rdData}, 16'h0080);
    busOp(4'h4, 1'b0, 1'b0, 8'h00);
    chk("R2 unbuffered B", capB, 16'd10);
    chk("R2 D untouched", capD, 16'd0);
    chk("R2 flags A B", {8'h0, rdData}, 16'h00C0);
    bufEnB = 1'b1;
    runTicks(2);
    busOp(4'h4, 1'b0, 1'b0, 8'h00);
    chk("R6 buffered B", capB, 16'd12);
    chk("R6 shifted into D", capD, 16'd10);

    // R9 low-power wipe, including read history
    busOp(4'h0, 1'b1, 1'b0, 8'h00);
    lowPower = 1'b1;
    @(negedge clk);
    lowPower = 1'b0;
    chk("R9 wiped status", {8'h0, rdData}, 16'h0000);
    busOp(4'h8, 1'b0, 1'b0, 8'h00);
    busOp(4'h0, 1'b0, 1'b1, 8'h00);
    chk("R9 history dropped", {8'h0, rdData}, 16'h0080);
    busOp(4'h0, 1'b1, 1'b0, 8'h00);
    busOp(4'h0, 1'b0, 1'b1, 8'h00);
    chk("R4 read then clear", {8'h0, rdData}, 16'h0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule